// File: doc/BRIEF.md
# Memory Clock Rate Change Sequencer

This controller-side sequencer moves an SDRAM interface to a new clock rate by passing through precharge power-down. A rate change is never attempted while the memory is in normal operation. When a change is requested, the block marks itself busy so that the rest of the controller stops issuing commands. It waits until every bank reports closed and then pulls the clock enable low. It keeps the clock enable low for a minimum number of cycles before it tells the clock generator that the switch may begin.

The clock generator signals that it has started by dropping its stable flag, and that it has finished by raising it again. The clock enable stays low for that whole interval. Once the clock is stable the sequencer raises the clock enable and waits a short exit gap. It then issues two commands: an extended mode register write that resets the DLL, and a mode register write that carries the new CAS latency. After a programmable relock interval it reports ready. Ready stays asserted until the requester withdraws the request, and the block then returns to idle. The encoding of the commands at the memory pins is left to the command path downstream.

Top module: `clk_freq_seq`

## Requirements
- R1: After reset the outputs are cke=1, busy=0, ready=0, sw_ok=0 and cmd_valid=0.
- R2: busy goes high in the cycle after chg_req is first sampled high in idle. It stays high until ready rises, and in that cycle busy goes low. While banks_idle is low, cke stays high.
- R3: cke falls in the cycle after banks_idle is sampled high while the block waits for the banks to close.
- R4: sw_ok rises exactly MIN_LOW (default 2) cycles after cke falls, and never while cke is high or has been low for fewer than 2 cycles.
- R5: cke stays low after sw_ok until clk_stable has been seen low and then high. cke rises in the cycle after clk_stable is sampled high.
- R6: EXIT_CYC (default 2) cycles after cke rises, a one-cycle DLL-reset command appears (cmd_valid=1, cmd_kind=2'b01). It is followed in the next cycle by a one-cycle mode command (cmd_valid=1, cmd_kind=2'b10) with mr_cl set to the new CAS latency. No command appears while cke is low, or in the first cycle after cke rises.
- R7: ready rises N+1 cycles after the mode command cycle. N is the relock count; a relock input of 0 selects the default of 200 cycles.
- R8: new_cl and relock_cyc are captured in the cycle the request is accepted. Later changes to them have no effect on mr_cl or on the relock time.
- R9: Dropping chg_req before ready does not shorten or abort the sequence. With ready high, ready holds while chg_req stays high. Once chg_req is low, ready falls in the following cycle and the block is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chg_req | input | 1 | Level request for a clock rate change |
| banks_idle | input | 1 | All banks are precharged |
| clk_stable | input | 1 | Clock generator output is stable |
| new_cl | input | CL_W | CAS latency for the new rate |
| relock_cyc | input | RELOCK_W | DLL relock wait in cycles, 0 selects the default |
| cke | output | 1 | Clock enable to the memory |
| sw_ok | output | 1 | Clock generator may start switching |
| busy | output | 1 | Block all other memory commands |
| ready | output | 1 | New rate is usable |
| cmd_valid | output | 1 | A mode register command is issued this cycle |
| cmd_kind | output | 2 | 2'b01 DLL-reset extended mode write, 2'b10 mode write |
| mr_cl | output | CL_W | CAS latency field for the mode write |

## Verification
A state register that skips or repeats a step shows up at the ports within a cycle or two. Typical symptoms are sw_ok arriving with too few low clock-enable cycles behind it, a command issued while cke is low, or a mode command without the DLL reset just before it. A miscounted relock or exit window shows as a wrong gap between events. Each gap is measured in cycles from the mode command to ready, or from the cke rise to the DLL reset, so an off-by-one error is caught in the first sequence that takes that path. Inputs that are captured at the wrong time appear as a wrong mr_cl value or a wrong relock length, because the bench changes both inputs once the request has been accepted.

// File: rtl/clk_freq_seq.sv
module clk_freq_seq #(
  parameter int MIN_LOW    = 2,
  parameter int EXIT_CYC   = 2,
  parameter int RELOCK_W   = 16,
  parameter int DEF_RELOCK = 200,
  parameter int CL_W       = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                chg_req,
  input  logic                banks_idle,
  input  logic                clk_stable,
  input  logic [CL_W-1:0]     new_cl,
  input  logic [RELOCK_W-1:0] relock_cyc,
  output logic                cke,
  output logic                sw_ok,
  output logic                busy,
  output logic                ready,
  output logic                cmd_valid,
  output logic [1:0]          cmd_kind,
  output logic [CL_W-1:0]     mr_cl
);

  typedef enum logic [3:0] {
    S_IDLE, S_DRAIN, S_HOLD, S_SWITCH, S_STABLE,
    S_EXIT, S_DLL_RST, S_MODE, S_RELOCK, S_DONE
  } st_t;

  localparam logic [1:0] K_DLL  = 2'b01;
  localparam logic [1:0] K_MODE = 2'b10;

  st_t st, nxt;
  logic [RELOCK_W-1:0] cnt, relock_q;
  logic [CL_W-1:0]     cl_q;
  wire                 cnt_done = (cnt == '0);

  always_comb begin
    nxt = st;
    case (st)
      S_IDLE:    if (chg_req)     nxt = S_DRAIN;
      S_DRAIN:   if (banks_idle)  nxt = S_HOLD;
      S_HOLD:    if (cnt_done)    nxt = S_SWITCH;
      S_SWITCH:  if (!clk_stable) nxt = S_STABLE;
      S_STABLE:  if (clk_stable)  nxt = S_EXIT;
      S_EXIT:    if (cnt_done)    nxt = S_DLL_RST;
      S_DLL_RST:                  nxt = S_MODE;
      S_MODE:                     nxt = S_RELOCK;
      S_RELOCK:  if (cnt_done)    nxt = S_DONE;
      S_DONE:    if (!chg_req)    nxt = S_IDLE;
      default:                    nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      relock_q <= RELOCK_W'(DEF_RELOCK);
      cl_q     <= '0;
    end else begin
      st <= nxt;
      if (st == S_IDLE && chg_req) begin
        cl_q     <= new_cl;
        relock_q <= (relock_cyc == '0) ? RELOCK_W'(DEF_RELOCK) : relock_cyc;
      end
      if (nxt != st) begin
        case (nxt)
          S_HOLD:   cnt <= RELOCK_W'(MIN_LOW - 1);
          S_EXIT:   cnt <= RELOCK_W'(EXIT_CYC - 1);
          S_RELOCK: cnt <= relock_q - 1'b1;
          default:  cnt <= '0;
        endcase
      end else if (!cnt_done) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign cke       = !(st == S_HOLD || st == S_SWITCH || st == S_STABLE);
  assign sw_ok     = (st == S_SWITCH);
  assign busy      = !(st == S_IDLE || st == S_DONE);
  assign ready     = (st == S_DONE);
  assign cmd_valid = (st == S_DLL_RST || st == S_MODE);
  assign cmd_kind  = (st == S_DLL_RST) ? K_DLL : (st == S_MODE) ? K_MODE : 2'b00;
  assign mr_cl     = cl_q;

  AST_CKE_FALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> $past(banks_idle)); // R3
  AST_SWITCH_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_ok) |-> (!$past(cke) && !$past(cke, 2))); // R4
  AST_EXIT_ON_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> $past(clk_stable)); // R5
  AST_CMD_CKE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cke && $past(cke))); // R6
  AST_MODE_AFTER_DLL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == K_MODE) |-> $past(cmd_valid && cmd_kind == K_DLL)); // R6
  AST_READY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> !$past(chg_req)); // R9

endmodule

// File: tb/test_clk_freq_seq.sv
module test_clk_freq_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic chg_req = 0, banks_idle = 0, clk_stable = 1;
  logic [2:0]  new_cl = 0;
  logic [15:0] relock_cyc = 0;
  logic cke, sw_ok, busy, ready, cmd_valid;
  logic [1:0] cmd_kind;
  logic [2:0] mr_cl;

  int checks = 0, errors = 0;
  int exp_k[$], exp_v[$];
  int cyc = 0, t_fall = 0, t_rise = 0, t_mrs = 0;
  logic pcke = 1, psw = 0, prdy = 0;
  int gt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_freq_seq i_clk_freq_seq (
    .clk(clk), .rst_n(rst_n), .chg_req(chg_req), .banks_idle(banks_idle),
    .clk_stable(clk_stable), .new_cl(new_cl), .relock_cyc(relock_cyc),
    .cke(cke), .sw_ok(sw_ok), .busy(busy), .ready(ready),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .mr_cl(mr_cl));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string tag(input int k);
    case (k)
      1: return "R3 cke fall";
      2: return "R4 switch gap";
      3: return "R5 cke rise";
      4: return "R6 dll reset gap";
      5: return "R6 R8 mode cl";
      default: return "R7 relock gap";
    endcase
  endfunction

  task automatic got(input int k, input int v);
    if (exp_k.size() == 0) begin
      check(0, "R2 unexpected event", k, 0);
    end else begin
      int ek = exp_k.pop_front();
      int ev = exp_v.pop_front();
      check(ek == k, "R2 event order", k, ek);
      check(ev == v, tag(k), v, ev);
    end
  endtask

  // clock generator model: drops stable on sw_ok, raises it 4 cycles later
  always @(negedge clk) begin
    if (!rst_n) begin
      clk_stable = 1; gt = 0;
    end else if (gt > 0) begin
      gt = gt - 1;
      if (gt == 0) clk_stable = 1;
    end else if (sw_ok && clk_stable) begin
      clk_stable = 0; gt = 4;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (!cke && pcke) begin t_fall = cyc; got(1, 0); end
      if (sw_ok && !psw) got(2, cyc - t_fall);
      if (cke && !pcke) begin t_rise = cyc; got(3, 0); end
      if (cmd_valid && cmd_kind == 2'b01) got(4, cyc - t_rise);
      if (cmd_valid && cmd_kind == 2'b10) begin t_mrs = cyc; got(5, int'(mr_cl)); end
      if (ready && !prdy) got(6, cyc - t_mrs);
      if (cmd_valid && !cke) check(0, "R6 command with cke low", 1, 0);
      pcke = cke; psw = sw_ok; prdy = ready;
    end
  end

  task automatic do_change(input int cl, input int rly, input int bdly, input bit drop, input int expn);
    exp_k.push_back(1); exp_v.push_back(0);
    exp_k.push_back(2); exp_v.push_back(2);
    exp_k.push_back(3); exp_v.push_back(0);
    exp_k.push_back(4); exp_v.push_back(2);
    exp_k.push_back(5); exp_v.push_back(cl);
    exp_k.push_back(6); exp_v.push_back(expn + 1);
    @(negedge clk);
    new_cl = 3'(cl); relock_cyc = 16'(rly); banks_idle = 0; chg_req = 1;
    @(negedge clk);
    check(busy == 1, "R2 busy after request", busy, 1);
    for (int i = 0; i < bdly; i++) begin
      check(cke == 1, "R2 cke high while banks open", cke, 1);
      @(negedge clk);
    end
    banks_idle = 1;
    new_cl = 3'(~cl);
    relock_cyc = 16'd5;
    if (drop) begin
      repeat (3) @(negedge clk);
      chg_req = 0;
    end
    while (!ready) begin
      @(negedge clk);
      if (!ready) check(busy == 1, "R2 busy held", busy, 1);
    end
    check(busy == 0, "R2 busy low at ready", busy, 0);
    if (drop) begin
      @(negedge clk);
      check(ready == 0, "R9 return to idle", ready, 0);
    end else begin
      @(negedge clk);
      check(ready == 1, "R9 ready held", ready, 1);
      chg_req = 0;
      @(negedge clk);
      @(negedge clk);
      check(ready == 0, "R9 ready falls", ready, 0);
    end
    check(exp_k.size() == 0, "R7 events left", exp_k.size(), 0);
    check(cke == 1 && busy == 0, "R9 idle state", {cke, busy}, 2);
    banks_idle = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(cke == 1, "R1 reset cke", cke, 1);
    check(busy == 0, "R1 reset busy", busy, 0);
    check(ready == 0, "R1 reset ready", ready, 0);
    check(sw_ok == 0, "R1 reset sw_ok", sw_ok, 0);
    check(cmd_valid == 0, "R1 reset cmd_valid", cmd_valid, 0);
    do_change(3, 10, 5, 0, 10);
    do_change(5, 0, 0, 1, 200);
    do_change(2, 1, 2, 0, 1);
    repeat (3) @(negedge clk);
    check(exp_k.size() == 0, "R7 queue drained", exp_k.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule